// File: doc/BRIEF.md
# Cycle-Counting PWM Channel Generator

This block drives one PWM output. A shared divider supplies a base clock enable. The channel divides that enable by its own prescale factor to make a cycle tick. Each tick advances a cycle index through one output period. Whether a cycle is driven inactive or active depends on where it falls in the period. The period holds the programmed entire count plus one cycle. The cycles numbered (from one) up to the programmed active count are inactive, and every cycle after them is active.

A polarity bit selects the electrical level that counts as active. The channel runs only while its enable is high. While the enable is low, both counters stay at zero and the pin stays at the inactive level.

The entire and active counts are captured into shadow registers at each period boundary, and also continuously while the channel is disabled. Software can therefore rewrite them at any time without producing a truncated pulse. No data stream passes through the block, so all of its pins are plain level-sensitive controls and carry no valid/ready handshake.

Top module: `pwm_cycle_gen`

## Requirements
- R1: One output period lasts `entire_cnt + 1` cycle ticks. At each tick the cycle index steps by one, and after index `entire_cnt` it returns to 0.
- R2: Within a period, a cycle with zero-based index below `active_cnt` is driven at the inactive level. A cycle with an index at or above `active_cnt` is driven at the active level.
- R3: An `active_cnt` of 0 makes every cycle of the period active. An `active_cnt` greater than `entire_cnt` (for example entire 3 with active 4) makes the whole period inactive.
- R4: `prescale_m1` holds K-1. A cycle tick occurs once every K base enables, with K from 1 to 256. The prescaler advances only on clock edges where `base_tick` is high.
- R5: When `act_high` is 1 the active level is 1 and the inactive level is 0. When `act_high` is 0 both levels are inverted.
- R6: While `chan_en` is low, the prescaler and the cycle index are held at zero and `pwm_out` equals the inactive level. After `chan_en` rises, output starts at cycle 0 of a fresh period that uses the current counts.
- R7: While the channel runs, `entire_cnt` and `active_cnt` are sampled only at a period boundary. A change made mid-period first affects the next period.
- R8: While the channel runs, the cycle index never exceeds the captured entire count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Base clock enable from the shared pair divider |
| chan_en | input | 1 | Channel run enable |
| prescale_m1 | input | 8 | Prescale factor minus one |
| entire_cnt | input | 16 | Period length minus one, in cycles |
| active_cnt | input | 16 | Number of leading inactive cycles |
| act_high | input | 1 | 1: active level is high; 0: active level is low |
| pwm_out | output | 1 | PWM level |

## Verification
The assertions check four properties on every clock edge. The cycle index stays within the captured entire count and steps by one or wraps to zero. The prescaler freezes without a base enable. The shadow counts never move mid-period, and a disabled channel sits cleared at the inactive level. Only the bench scenarios can show the complete waveform shape, because that requires comparing the pin cycle by cycle against arithmetic expectations. These scenarios cover swept prescale, period and active counts in both polarities, the all-active and all-inactive extremes, gapped base enables, a mid-period rewrite and a restart after disable.

// File: rtl/pwm_cg_pkg.sv
package pwm_cg_pkg;
  localparam int unsigned DEF_PRE_W = 8;
  localparam int unsigned DEF_CNT_W = 16;

  // Inactive level for a given polarity selection.
  function automatic logic idle_level(input logic act_high);
    return ~act_high;
  endfunction
endpackage

// File: rtl/pwm_cg_prescaler.sv
module pwm_cg_prescaler #(
  parameter int unsigned PRE_W = pwm_cg_pkg::DEF_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             base_tick,
  input  logic [PRE_W-1:0] div_m1,
  output logic             cyc_tick,
  output logic [PRE_W-1:0] pre_cnt
);
  logic at_end;

  assign at_end   = (pre_cnt >= div_m1);
  assign cyc_tick = run & base_tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
    end else if (base_tick) begin
      if (at_end) pre_cnt <= '0;
      else        pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_cg_period.sv
module pwm_cg_period #(
  parameter int unsigned CNT_W = pwm_cg_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cyc_tick,
  input  logic [CNT_W-1:0] ent_in,
  input  logic [CNT_W-1:0] act_in,
  output logic [CNT_W-1:0] cyc_idx,
  output logic [CNT_W-1:0] ent_q,
  output logic [CNT_W-1:0] act_q,
  output logic             wrap
);
  logic last_cyc;

  assign last_cyc = (cyc_idx == ent_q);
  assign wrap     = cyc_tick & last_cyc;

  // Cycle index within the period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_idx <= '0;
    end else if (!run) begin
      cyc_idx <= '0;
    end else if (cyc_tick) begin
      if (last_cyc) cyc_idx <= '0;
      else          cyc_idx <= cyc_idx + 1'b1;
    end
  end

  // Shadow counts: follow inputs while idle, reload only on wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      act_q <= '0;
    end else if (!run || wrap) begin
      ent_q <= ent_in;
      act_q <= act_in;
    end
  end
endmodule

// File: rtl/pwm_cg_level.sv
module pwm_cg_level #(
  parameter int unsigned CNT_W = pwm_cg_pkg::DEF_CNT_W
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cyc_idx,
  input  logic [CNT_W-1:0] act_q,
  input  logic             act_high,
  output logic             pwm_out
);
  logic in_active;

  assign in_active = run && (cyc_idx >= act_q);

  always_comb begin
    if (in_active) pwm_out = act_high;
    else           pwm_out = pwm_cg_pkg::idle_level(act_high);
  end
endmodule

// File: rtl/pwm_cycle_gen.sv
module pwm_cycle_gen #(
  parameter int unsigned PRE_W = pwm_cg_pkg::DEF_PRE_W,
  parameter int unsigned CNT_W = pwm_cg_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             chan_en,
  input  logic [PRE_W-1:0] prescale_m1,
  input  logic [CNT_W-1:0] entire_cnt,
  input  logic [CNT_W-1:0] active_cnt,
  input  logic             act_high,
  output logic             pwm_out
);
  logic             cyc_tick;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cyc_idx;
  logic [CNT_W-1:0] ent_q;
  logic [CNT_W-1:0] act_q;
  logic             wrap;

  pwm_cg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (chan_en),
    .base_tick(base_tick),
    .div_m1   (prescale_m1),
    .cyc_tick (cyc_tick),
    .pre_cnt  (pre_cnt)
  );

  pwm_cg_period #(.CNT_W(CNT_W)) u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (chan_en),
    .cyc_tick(cyc_tick),
    .ent_in  (entire_cnt),
    .act_in  (active_cnt),
    .cyc_idx (cyc_idx),
    .ent_q   (ent_q),
    .act_q   (act_q),
    .wrap    (wrap)
  );

  pwm_cg_level #(.CNT_W(CNT_W)) u_lvl (
    .run     (chan_en),
    .cyc_idx (cyc_idx),
    .act_q   (act_q),
    .act_high(act_high),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/pwm_cg_checker.sv
module pwm_cg_checker #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             base_tick,
  input logic             act_high,
  input logic             pwm_out,
  input logic             cyc_tick,
  input logic             wrap,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [CNT_W-1:0] cyc_idx,
  input logic [CNT_W-1:0] ent_q,
  input logic [CNT_W-1:0] act_q
);
  assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cyc_idx <= ent_q));

  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc_tick && (cyc_idx != ent_q)) |=> (cyc_idx == CNT_W'($past(cyc_idx) + 1'b1)));

  assert_idx_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap) |=> (cyc_idx == '0));

  assert_pre_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !base_tick) |=> $stable(pre_cnt));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(ent_q) && $stable(act_q)));

  assert_off_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((cyc_idx == '0) && (pre_cnt == '0)));

  assert_off_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == !act_high));
endmodule

bind pwm_cycle_gen pwm_cg_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (chan_en),
  .base_tick(base_tick),
  .act_high (act_high),
  .pwm_out  (pwm_out),
  .cyc_tick (cyc_tick),
  .wrap     (wrap),
  .pre_cnt  (pre_cnt),
  .cyc_idx  (cyc_idx),
  .ent_q    (ent_q),
  .act_q    (act_q)
);

// File: tb/test_pwm_cycle_gen.sv
module test_pwm_cycle_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        chan_en = 1'b0;
  logic [7:0]  prescale_m1 = '0;
  logic [15:0] entire_cnt = '0;
  logic [15:0] active_cnt = '0;
  logic        act_high = 1'b1;
  logic        pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  int n_cyc = 0;

  // Reference state derived from the requirements.
  int m_sub = 0, m_idx = 0, m_ent = 0, m_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cycle_gen i_pwm_cycle_gen (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .chan_en(chan_en),
    .prescale_m1(prescale_m1), .entire_cnt(entire_cnt), .active_cnt(active_cnt),
    .act_high(act_high), .pwm_out(pwm_out)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", n_cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string rq, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (idx %0d ent %0d act %0d)",
               rq, act, exp, m_idx, m_ent, m_act);
    end
  endtask

  // One clock: advance reference at the edge, compare at the falling edge.
  task automatic step(input string rq);
    logic exp;
    @(posedge clk);
    if (!chan_en) begin
      m_sub = 0; m_idx = 0; m_ent = int'(entire_cnt); m_act = int'(active_cnt);
    end else if (base_tick) begin
      if (m_sub >= int'(prescale_m1)) begin
        m_sub = 0;
        if (m_idx == m_ent) begin
          m_idx = 0; m_ent = int'(entire_cnt); m_act = int'(active_cnt);
        end else m_idx++;
      end else m_sub++;
    end
    @(negedge clk);
    exp = (chan_en && (m_idx >= m_act)) ? act_high : ~act_high;
    check(rq, pwm_out, exp);
  endtask

  initial begin
    string rq;
    int rises, first_rise, second_rise;
    logic prev;

    repeat (2) @(negedge clk);
    check("R6 reset level", pwm_out, 1'b0);
    rst_n = 1'b1;
    step("R6 idle");

    // Sweep prescale, period, active count and polarity (R1 R2 R3 R5).
    base_tick = 1'b1;
    for (int k = 0; k < 3; k++)
      for (int e = 0; e < 5; e++)
        for (int a = 0; a < 7; a++)
          for (int p = 0; p < 2; p++) begin
            prescale_m1 = 8'(k); entire_cnt = 16'(e); active_cnt = 16'(a);
            act_high = p[0];
            if (a == 0 || a > e) rq = $sformatf("R3 k%0d e%0d a%0d p%0d", k, e, a, p);
            else if (p == 0)     rq = $sformatf("R5 k%0d e%0d a%0d", k, e, a);
            else                 rq = $sformatf("R2 R1 k%0d e%0d a%0d", k, e, a);
            chan_en = 1'b1;
            for (int c = 0; c < 2*(e+1)*(k+1) + 2; c++) step(rq);
            chan_en = 1'b0;
            step("R6 off");
          end

    // R1: rising-edge spacing equals (entire+1)*K.
    prescale_m1 = 8'd1; entire_cnt = 16'd4; active_cnt = 16'd2; act_high = 1'b1;
    chan_en = 1'b1; rises = 0; first_rise = 0; second_rise = 0; prev = pwm_out;
    for (int c = 0; c < 40; c++) begin
      step("R1 run");
      if (pwm_out && !prev) begin
        rises++;
        if (rises == 1) first_rise = c;
        if (rises == 2) second_rise = c;
      end
      prev = pwm_out;
    end
    n_chk++;
    if (second_rise - first_rise != 10) begin
      n_fail++;
      $display("FAIL R1 period: actual %0d expected 10", second_rise - first_rise);
    end
    chan_en = 1'b0; step("R6 off");

    // R4: gapped base enable, K=3.
    prescale_m1 = 8'd2; entire_cnt = 16'd3; active_cnt = 16'd1; chan_en = 1'b1;
    for (int c = 0; c < 60; c++) begin
      base_tick = (c % 3 == 1);
      step("R4 gapped");
    end
    base_tick = 1'b1; chan_en = 1'b0; step("R6 off");

    // R7: rewrite mid-period, old values finish the period.
    prescale_m1 = 8'd0; entire_cnt = 16'd5; active_cnt = 16'd3; chan_en = 1'b1;
    for (int c = 0; c < 3; c++) step("R7 before");
    entire_cnt = 16'd2; active_cnt = 16'd0;
    for (int c = 0; c < 14; c++) step("R7 after");

    // R6: disable mid-period then restart at a fresh period.
    entire_cnt = 16'd6; active_cnt = 16'd4;
    for (int c = 0; c < 9; c++) step("R6 run");
    chan_en = 1'b0;
    for (int c = 0; c < 4; c++) step("R6 held");
    chan_en = 1'b1;
    for (int c = 0; c < 16; c++) step("R6 restart");

    summary();
    $finish;
  end
endmodule